// File: doc/BRIEF.md
# Cascaded Vectored Interrupt Controller

This block collects interrupt requests from sixteen lines and presents them to a processor through one request wire and a strobe-driven acknowledge. Two identical eight-line units are built inside it. The first unit faces the processor. The second unit feeds its own request into one line of the first unit, which is the cascade line. Each line can be blocked by a mask bit. Each line can be set to catch a single rising transition or to follow the level of the wire.

When a pending line is not masked, `intr_o` goes high. The processor then pulses `inta_i` for one cycle. On the next cycle the block returns an eight-bit vector for one cycle, marked by `vec_valid_o`. The vector is a programmable per-unit base with the three-bit index of the winning line appended to it. If the winning line of the first unit is the cascade line, the second unit answers with its own vector and the first unit stays silent. Software sets the masks, trigger modes and bases through a simple write port.

Top module: `irq_cascade_ctl`

## Requirements
- R1: Lines `irq_i[7:0]` belong to the master unit. Lines `irq_i[15:8]` belong to the slave unit, and index i within that unit is slave line 8+i.
- R2: A line whose mask bit is 1 never causes `intr_o` to go high.
- R3: Once the unit's mask has been written, any pending line that is not masked drives `intr_o` high.
- R4: Trigger register bit i set to 1 selects edge mode for line i. In edge mode, one low-to-high change is latched and stays pending after the wire falls, and a wire held high does not retrigger. Bit i at 0 selects level mode, where the line is pending exactly while its wire is high. After reset every line is in level mode.
- R5: Master line CASC_LINE (default 2) is driven by the slave unit's request and is always treated as level, whatever its trigger bit holds.
- R6: An edge-latched request is cleared when an acknowledge selects that line. Once nothing else is pending, `intr_o` falls.
- R7: Among the pending lines that are not masked, the lowest index wins the acknowledge.
- R8: `vec_valid_o` is high for exactly one cycle, the cycle after `inta_i` is sampled high. `vec_o` is then the unit's base, taken from bits 7:3 of the last base write, followed by the 3-bit winning index.
- R9: When the master's winner is the cascade line, the slave returns its own vector. The master drives no vector for that acknowledge, and only one valid pulse occurs.
- R10: After reset every mask bit is 1, and a unit raises no request until its mask register has been written.
- R11: An acknowledge that finds nothing pending returns that unit's base with index 7.
- R12: Configuration writes use `cfg_addr_i` 0 for the mask, 1 for the trigger mode and 2 for the base. `cfg_slave_i` = 1 sends the write to the slave unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_i | input | 16 | Request lines; 7:0 go to the master, 15:8 to the slave |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_slave_i | input | 1 | Write target: 0 master, 1 slave |
| cfg_addr_i | input | 2 | 0 mask, 1 trigger mode, 2 vector base |
| cfg_data_i | input | 8 | Write data; the base uses bits 7:3 |
| inta_i | input | 1 | Acknowledge strobe from the processor |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | One-cycle marker that `vec_o` holds a vector |
| vec_o | output | 8 | Returned interrupt vector |

## Verification
A level wire held across an acknowledge shows that the request persists. A one-cycle pulse on an edge line shows that the event is latched and then cleared by the acknowledge. A wire held high on an edge line shows that it does not retrigger. Two simultaneous levels, and a master line competing against the cascade line, separate the lowest-index rule from any ordering of arrival. A slave-side request shows that exactly one vector comes back with the slave's base. Writing an all-ones mask and leaving a unit unwritten show that masking and arming hold back the request. An acknowledge with nothing pending exposes the default index 7.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int IRQ_LINES = 8;
    localparam int IRQ_VEC_W = 8;

    typedef enum logic [1:0] {
        CFG_MASK = 2'd0,
        CFG_TRIG = 2'd1,
        CFG_BASE = 2'd2
    } cfg_addr_e;
endpackage

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int LINES = irq_pkg::IRQ_LINES,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0] req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_unit.sv
module irq_unit
    import irq_pkg::*;
#(
    parameter int LINES = IRQ_LINES,
    parameter int VEC_W = IRQ_VEC_W,
    parameter logic [LINES-1:0] CASC_MASK = '0,
    localparam int IDX_W = $clog2(LINES),
    localparam int BASE_W = VEC_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_i,
    input  logic             wr_i,
    input  cfg_addr_e        wr_addr_i,
    input  logic [VEC_W-1:0] wr_data_i,
    input  logic             ack_i,
    output logic             intr_o,
    output logic             pass_o,
    output logic             vld_o,
    output logic [VEC_W-1:0] vec_o
);
    typedef struct packed {
        logic [LINES-1:0]  s1;
        logic [LINES-1:0]  s2;
        logic [LINES-1:0]  edg;
        logic [LINES-1:0]  mask;
        logic [LINES-1:0]  trig;
        logic [BASE_W-1:0] base;
        logic              armed;
        logic              intr;
        logic              vld;
        logic [VEC_W-1:0]  vec;
    } unit_state_t;

    unit_state_t st_q, st_d;

    logic [LINES-1:0] rise, trig_eff, pend, req, clr, win_oh;
    logic             any;
    logic [IDX_W-1:0] win, idx;
    logic             answer;

    irq_prio #(.LINES(LINES)) u_prio (
        .req_i(req),
        .any_o(any),
        .idx_o(win)
    );

    assign pass_o = any && CASC_MASK[win];
    assign win_oh = LINES'(1) << win;

    always_comb begin
        st_d     = st_q;
        st_d.s1  = line_i;
        st_d.s2  = st_q.s1;
        rise     = st_q.s1 & ~st_q.s2;
        trig_eff = st_q.trig & ~CASC_MASK;
        pend     = (st_q.edg & trig_eff) | (st_q.s1 & ~trig_eff);
        req      = pend & ~st_q.mask;
        idx      = any ? win : IDX_W'(LINES - 1);
        answer   = ack_i && !pass_o;
        clr      = '0;
        if (answer && any) clr = win_oh;
        st_d.edg  = ((st_q.edg & ~clr) | rise) & trig_eff;
        st_d.vld  = answer;
        if (answer) st_d.vec = {st_q.base, idx};
        st_d.intr = st_q.armed && (|req);
        if (wr_i) begin
            case (wr_addr_i)
                CFG_MASK: begin
                    st_d.mask  = wr_data_i[LINES-1:0];
                    st_d.armed = 1'b1;
                end
                CFG_TRIG: st_d.trig = wr_data_i[LINES-1:0];
                CFG_BASE: st_d.base = wr_data_i[VEC_W-1:IDX_W];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign intr_o = st_q.intr;
    assign vld_o  = st_q.vld;
    assign vec_o  = st_q.vec;

    assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((&st_q.mask) && $past(&st_q.mask)) |-> !intr_o);

    assert_unarmed_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && $past(!st_q.armed)) |-> !intr_o);

    assert_vld_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> ($past(ack_i) && vec_o[VEC_W-1:IDX_W] == $past(st_q.base)));

    assert_edge_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (answer && any && |(win_oh & trig_eff & ~rise)) |=> ((st_q.edg & $past(win_oh)) == '0));
endmodule

// File: rtl/irq_cascade_ctl.sv
module irq_cascade_ctl
    import irq_pkg::*;
#(
    parameter int LINES = IRQ_LINES,
    parameter int VEC_W = IRQ_VEC_W,
    parameter int CASC_LINE = 2,
    localparam int ALL_LINES = 2 * LINES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ALL_LINES-1:0] irq_i,
    input  logic                 cfg_we_i,
    input  logic                 cfg_slave_i,
    input  logic [1:0]           cfg_addr_i,
    input  logic [VEC_W-1:0]     cfg_data_i,
    input  logic                 inta_i,
    output logic                 intr_o,
    output logic                 vec_valid_o,
    output logic [VEC_W-1:0]     vec_o
);
    localparam logic [LINES-1:0] M_CASC = LINES'(1) << CASC_LINE;

    logic             s_intr, s_pass, s_vld, s_ack;
    logic             m_intr, m_pass, m_vld;
    logic [VEC_W-1:0] s_vec, m_vec;
    logic [LINES-1:0] m_lines;
    cfg_addr_e        addr;

    assign addr = cfg_addr_e'(cfg_addr_i);

    always_comb begin
        m_lines            = irq_i[LINES-1:0];
        m_lines[CASC_LINE] = s_intr;
    end

    assign s_ack = inta_i && m_pass;

    irq_unit #(.LINES(LINES), .VEC_W(VEC_W), .CASC_MASK('0)) u_slave (
        .clk(clk), .rst_n(rst_n),
        .line_i(irq_i[ALL_LINES-1:LINES]),
        .wr_i(cfg_we_i && cfg_slave_i),
        .wr_addr_i(addr), .wr_data_i(cfg_data_i),
        .ack_i(s_ack),
        .intr_o(s_intr), .pass_o(s_pass), .vld_o(s_vld), .vec_o(s_vec)
    );

    irq_unit #(.LINES(LINES), .VEC_W(VEC_W), .CASC_MASK(M_CASC)) u_master (
        .clk(clk), .rst_n(rst_n),
        .line_i(m_lines),
        .wr_i(cfg_we_i && !cfg_slave_i),
        .wr_addr_i(addr), .wr_data_i(cfg_data_i),
        .ack_i(inta_i),
        .intr_o(m_intr), .pass_o(m_pass), .vld_o(m_vld), .vec_o(m_vec)
    );

    assign intr_o      = m_intr;
    assign vec_valid_o = m_vld | s_vld;
    assign vec_o       = m_vld ? m_vec : s_vec;

    assert_single_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m_vld, s_vld}));

    assert_slave_vld_only_on_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        s_vld |-> $past(inta_i && m_pass));

    assert_slave_no_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !s_pass);
endmodule

// File: tb/irq_cascade_ctl_tb.sv
module irq_cascade_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq = '0;
    logic        we = 1'b0, sl = 1'b0, inta = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  data = '0;
    logic        intr, vvld;
    logic [7:0]  vec;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    irq_cascade_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq),
        .cfg_we_i(we), .cfg_slave_i(sl), .cfg_addr_i(addr), .cfg_data_i(data),
        .inta_i(inta), .intr_o(intr), .vec_valid_o(vvld), .vec_o(vec)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input bit slave, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; sl = slave; addr = a; data = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    // pulse inta, return vector and number of valid cycles seen
    task automatic ack(output logic [7:0] v, output int pulses);
        @(negedge clk);
        inta = 1'b1;
        @(negedge clk);
        inta = 1'b0;
        v = vec;
        pulses = vvld ? 1 : 0;
        repeat (3) begin
            @(negedge clk);
            if (vvld) pulses++;
        end
    endtask

    task automatic t_reset();
        check(intr == 1'b0, "R10 reset intr", intr, 0);
        check(vvld == 1'b0, "R8 reset valid", vvld, 0);
    endtask

    task automatic t_unarmed();
        irq[0] = 1'b1;
        idle(5);
        check(intr == 1'b0, "R10 unarmed", intr, 0);
    endtask

    task automatic t_masked();
        cfg(1'b0, 2'd2, 8'h40);
        cfg(1'b0, 2'd0, 8'hFF);
        idle(5);
        check(intr == 1'b0, "R2 all masked", intr, 0);
    endtask

    task automatic t_level();
        logic [7:0] v; int p;
        cfg(1'b0, 2'd0, 8'h00);
        idle(4);
        check(intr == 1'b1, "R3 unmasked level", intr, 1);
        ack(v, p);
        check(v == 8'h40, "R8 vector line0", v, 8'h40);
        check(p == 1, "R8 one pulse", p, 1);
        idle(3);
        check(intr == 1'b1, "R4 level persists", intr, 1);
        irq[0] = 1'b0;
        idle(4);
        check(intr == 1'b0, "R4 level drop", intr, 0);
    endtask

    task automatic t_prio();
        logic [7:0] v; int p;
        irq[5] = 1'b1; irq[3] = 1'b1;
        idle(4);
        ack(v, p);
        check(v == 8'h43, "R7 lowest wins", v, 8'h43);
        irq[5] = 1'b0; irq[3] = 1'b0;
        idle(4);
    endtask

    task automatic t_edge();
        logic [7:0] v; int p;
        cfg(1'b0, 2'd1, 8'h10);
        @(negedge clk); irq[4] = 1'b1;
        @(negedge clk); irq[4] = 1'b0;
        idle(5);
        check(intr == 1'b1, "R4 edge latched", intr, 1);
        ack(v, p);
        check(v == 8'h44, "R8 edge vector", v, 8'h44);
        idle(3);
        check(intr == 1'b0, "R6 edge cleared", intr, 0);
        irq[4] = 1'b1;
        idle(5);
        ack(v, p);
        idle(4);
        check(intr == 1'b0, "R4 held edge no retrigger", intr, 0);
        irq[4] = 1'b0;
        idle(2);
    endtask

    task automatic t_cascade();
        logic [7:0] v; int p;
        cfg(1'b1, 2'd2, 8'h80);
        cfg(1'b1, 2'd0, 8'h00);
        irq[9] = 1'b1;
        idle(8);
        check(intr == 1'b1, "R5 slave request", intr, 1);
        ack(v, p);
        check(v == 8'h81, "R9 slave vector line9", v, 8'h81);
        check(p == 1, "R9 single answer", p, 1);
        irq[1] = 1'b1;
        idle(5);
        ack(v, p);
        check(v == 8'h41, "R7 master line1 beats cascade", v, 8'h41);
        irq[1] = 1'b0; irq[9] = 1'b0;
        idle(8);
        check(intr == 1'b0, "R1 all quiet", intr, 0);
    endtask

    task automatic t_spurious();
        logic [7:0] v; int p;
        ack(v, p);
        check(v == 8'h47, "R11 spurious index7", v, 8'h47);
        check(p == 1, "R12 base write kept", p, 1);
    endtask

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_unarmed();
        t_masked();
        t_level();
        t_prio();
        t_edge();
        t_cascade();
        t_spurious();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule